// File: doc/BRIEF.md
# Five-Stage Interlocked Pipeline Core

This block is a small in-order processor built as five stages: fetch, decode, execute, memory access and writeback. An edge-triggered pipeline register sits between each pair of stages. It has eight 32-bit general registers and six operations: add, nand, load word, store word, branch-if-equal and noop. The instruction and data memories are word arrays held inside the core. While the core is held in reset, a loader fills them through a plain write port.

The core has no forwarding paths. When an instruction in decode names a register that an older instruction in execute or memory is still going to write, decode holds. The program counter and the fetch/decode register keep their values, and a noop enters execute. The register file is write-through: a read in the same cycle as a write to the same register returns the new value. A consumer can therefore leave decode as soon as its producer reaches writeback.

Branches are assumed not taken, and fetch carries on sequentially. A branch is resolved when it reaches the memory stage. If it is taken, the PC is loaded with the target and the three younger instructions are discarded. Monitor ports give combinational reads of any register and of any word in either memory.

Top module: `pipe5_core`

## Requirements
- R1: While `rst_n` is low, all eight registers read 0 through the monitor port. Every pipeline stage holds a noop and the PC is 0.
- R2: Instruction words use these fields:
  - opcode at bits 24:22, with add=0, nand=1, lw=2, sw=3, beq=4, noop=7;
  - source A at bits 21:19 and source B at bits 18:16;
  - a signed 16-bit offset at bits 15:0;
  - for add and nand, the destination at bits 2:0.

  add writes A+B and nand writes ~(A&B). An instruction at address 0 writes its result at the 5th rising edge after reset is released.
- R3: lw writes dmem[A+sext(offset)] into the register named by the source B field. sw stores the value of register B into dmem[A+sext(offset)]. A negative offset addresses below A.
- R4: Opcodes 5 and 6 behave as noop. They write nothing and never cause a stall.
- R5: When an instruction reads a register written by the instruction directly ahead of it, it stays in decode for exactly two extra cycles. It then sees the new value. A stall never lasts longer than two consecutive cycles.
- R6: With one unrelated instruction between producer and consumer, the consumer stalls one cycle. With two or more between them, it does not stall.
- R7: sw, beq and noop never cause a stall, whatever their bits 2:0 hold.
- R8: When no stall and no taken branch occurs, the PC advances by one each cycle. A beq that is not taken costs no cycles.
- R9: A taken beq loads the PC with its address + 1 + offset when it is in the memory stage. It turns the three younger instructions into noops, so none of them writes a register.
- R10: During a stall, the PC and the fetch/decode register hold their values and a noop enters execute.
- R11: The load ports write imem and dmem words. The monitor ports read back the stored words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the pipeline and registers |
| imem_we | input | 1 | Instruction memory load strobe |
| imem_waddr | input | IAW | Instruction memory load address |
| imem_wdata | input | 32 | Instruction word to load |
| dmem_we | input | 1 | Data memory load strobe (takes priority over a store) |
| dmem_waddr | input | DAW | Data memory load address |
| dmem_wdata | input | 32 | Data word to load |
| mon_iaddr | input | IAW | Instruction memory monitor address |
| mon_idata | output | 32 | Instruction word at `mon_iaddr` |
| mon_daddr | input | DAW | Data memory monitor address |
| mon_ddata | output | 32 | Data word at `mon_daddr` |
| mon_rsel | input | 3 | Register monitor select |
| mon_rdata | output | 32 | Stored value of register `mon_rsel` |

## Verification
The hardest behaviour to reach from the ports is the exact length of an interlock. A wrong stall count still produces correct register values; only the cycle in which a result lands changes. The bench therefore places producer and consumer zero, one and two slots apart. It samples the destination register at the edge just before the expected write and again at the edge of the write. Likewise, a taken branch is followed by three writing instructions whose registers must stay zero. The undefined opcodes sit right behind a load into the register they name, so any stall they caused would delay a later result by two cycles.

// File: rtl/p5_pkg.sv
`timescale 1ns/1ps
package p5_pkg;
  localparam int WORD_W = 32;
  localparam int NREGS  = 8;
  localparam int RSEL_W = 3;
  localparam int OFF_W  = 16;
  localparam int OP_LO  = 22;
  localparam int RA_LO  = 19;
  localparam int RB_LO  = 16;
  localparam int RD_LO  = 0;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_NAND = 3'd1,
    OP_LW   = 3'd2,
    OP_SW   = 3'd3,
    OP_BEQ  = 3'd4,
    OP_NOOP = 3'd7
  } op_e;

  typedef struct packed {
    logic [WORD_W-1:0] instr;
    logic [WORD_W-1:0] pc1;
  } ifid_t;

  typedef struct packed {
    op_e               op;
    logic [RSEL_W-1:0] rd;
    logic [WORD_W-1:0] va;
    logic [WORD_W-1:0] vb;
    logic [WORD_W-1:0] off;
    logic [WORD_W-1:0] pc1;
  } idex_t;

  typedef struct packed {
    op_e               op;
    logic [RSEL_W-1:0] rd;
    logic [WORD_W-1:0] alu;
    logic [WORD_W-1:0] vb;
    logic [WORD_W-1:0] target;
    logic              eq;
  } exmem_t;

  typedef struct packed {
    op_e               op;
    logic [RSEL_W-1:0] rd;
    logic [WORD_W-1:0] alu;
    logic [WORD_W-1:0] mdata;
  } memwb_t;

  localparam logic [WORD_W-1:0] NOOP_WORD = {7'd0, 3'd7, 22'd0};

  // Undefined encodings are treated as noop.
  function automatic op_e op_of(input logic [WORD_W-1:0] w);
    case (w[OP_LO +: 3])
      3'd0:    return OP_ADD;
      3'd1:    return OP_NAND;
      3'd2:    return OP_LW;
      3'd3:    return OP_SW;
      3'd4:    return OP_BEQ;
      default: return OP_NOOP;
    endcase
  endfunction

  function automatic logic writes_reg(input op_e op);
    return (op == OP_ADD) || (op == OP_NAND) || (op == OP_LW);
  endfunction

  function automatic logic [RSEL_W-1:0] dest_of(input logic [WORD_W-1:0] w);
    return (op_of(w) == OP_LW) ? w[RB_LO +: RSEL_W] : w[RD_LO +: RSEL_W];
  endfunction

  function automatic logic [WORD_W-1:0] sext_off(input logic [OFF_W-1:0] o);
    return {{(WORD_W-OFF_W){o[OFF_W-1]}}, o};
  endfunction

  function automatic logic [WORD_W-1:0] alu_calc(input op_e op, input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b,
                                                 input logic [WORD_W-1:0] off);
    case (op)
      OP_ADD:       return a + b;
      OP_NAND:      return ~(a & b);
      OP_LW, OP_SW: return a + off;
      default:      return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] branch_target(input logic [WORD_W-1:0] pc1,
                                                      input logic [WORD_W-1:0] off);
    return pc1 + off;
  endfunction
endpackage

// File: rtl/p5_wordmem.sv
`timescale 1ns/1ps
module p5_wordmem #(
  parameter int DEPTH = 64,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr0,
  output logic [W-1:0]  rdata0,
  input  logic [AW-1:0] raddr1,
  output logic [W-1:0]  rdata1
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata0 = mem[raddr0];
  assign rdata1 = mem[raddr1];
endmodule

// File: rtl/p5_regfile.sv
`timescale 1ns/1ps
module p5_regfile #(
  parameter int N    = 8,
  parameter int W    = 32,
  localparam int SW  = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] ra,
  output logic [W-1:0]  rdata_a,
  input  logic [SW-1:0] rb,
  output logic [W-1:0]  rdata_b,
  input  logic          we,
  input  logic [SW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [SW-1:0] mon_sel,
  output logic [W-1:0]  mon_data
);
  logic [W-1:0] rf [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rf[i] <= '0;
    end else if (we) begin
      rf[waddr] <= wdata;
    end
  end

  // Write-through: a same-cycle write is visible to decode.
  assign rdata_a  = (we && (waddr == ra)) ? wdata : rf[ra];
  assign rdata_b  = (we && (waddr == rb)) ? wdata : rf[rb];
  assign mon_data = rf[mon_sel];
endmodule

// File: rtl/p5_hazard.sv
`timescale 1ns/1ps
module p5_hazard #(
  parameter int NSTG = 2,
  parameter int SW   = 3
) (
  input  logic                     dec_active,
  input  logic [SW-1:0]            dec_ra,
  input  logic [SW-1:0]            dec_rb,
  input  logic [NSTG-1:0]          prod_wr,
  input  logic [NSTG-1:0][SW-1:0]  prod_rd,
  output logic                     stall
);
  logic [NSTG-1:0] hit;

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    assign hit[s] = prod_wr[s] && ((prod_rd[s] == dec_ra) || (prod_rd[s] == dec_rb));
  end

  assign stall = dec_active && (|hit);
endmodule

// File: rtl/pipe5_core.sv
`timescale 1ns/1ps
module pipe5_core
  import p5_pkg::*;
#(
  parameter int IMEM_DEPTH = 64,
  parameter int DMEM_DEPTH = 64,
  localparam int IAW = $clog2(IMEM_DEPTH),
  localparam int DAW = $clog2(DMEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              imem_we,
  input  logic [IAW-1:0]    imem_waddr,
  input  logic [WORD_W-1:0] imem_wdata,
  input  logic              dmem_we,
  input  logic [DAW-1:0]    dmem_waddr,
  input  logic [WORD_W-1:0] dmem_wdata,
  input  logic [IAW-1:0]    mon_iaddr,
  output logic [WORD_W-1:0] mon_idata,
  input  logic [DAW-1:0]    mon_daddr,
  output logic [WORD_W-1:0] mon_ddata,
  input  logic [RSEL_W-1:0] mon_rsel,
  output logic [WORD_W-1:0] mon_rdata
);
  localparam ifid_t  IFID_NOP  = '{instr: NOOP_WORD, pc1: '0};
  localparam idex_t  IDEX_NOP  = '{op: OP_NOOP, rd: '0, va: '0, vb: '0, off: '0, pc1: '0};
  localparam exmem_t EXMEM_NOP = '{op: OP_NOOP, rd: '0, alu: '0, vb: '0, target: '0, eq: 1'b0};
  localparam memwb_t MEMWB_NOP = '{op: OP_NOOP, rd: '0, alu: '0, mdata: '0};

  logic [WORD_W-1:0] pc_q;
  ifid_t  ifid_q,  ifid_d;
  idex_t  idex_q,  idex_d;
  exmem_t exmem_q, exmem_d;
  memwb_t memwb_q, memwb_d;

  // Named events for the checker
  logic              hz_stall;
  logic              br_take;
  logic [WORD_W-1:0] br_target;
  logic              ifid_nop, idex_nop, exmem_nop;

  // Fetch
  logic [WORD_W-1:0] f_instr;
  p5_wordmem #(.DEPTH(IMEM_DEPTH), .W(WORD_W)) u_imem (
    .clk(clk), .we(imem_we), .waddr(imem_waddr), .wdata(imem_wdata),
    .raddr0(pc_q[IAW-1:0]), .rdata0(f_instr),
    .raddr1(mon_iaddr), .rdata1(mon_idata)
  );

  always_comb begin
    ifid_d.instr = f_instr;
    ifid_d.pc1   = pc_q + 1'b1;
  end

  // Decode
  op_e               d_op;
  logic [RSEL_W-1:0] d_ra, d_rb;
  logic [WORD_W-1:0] rf_a, rf_b;
  logic              wb_we;
  logic [WORD_W-1:0] wb_data;

  assign d_op = op_of(ifid_q.instr);
  assign d_ra = ifid_q.instr[RA_LO +: RSEL_W];
  assign d_rb = ifid_q.instr[RB_LO +: RSEL_W];

  p5_regfile #(.N(NREGS), .W(WORD_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra(d_ra), .rdata_a(rf_a), .rb(d_rb), .rdata_b(rf_b),
    .we(wb_we), .waddr(memwb_q.rd), .wdata(wb_data),
    .mon_sel(mon_rsel), .mon_data(mon_rdata)
  );

  always_comb begin
    idex_d.op  = d_op;
    idex_d.rd  = dest_of(ifid_q.instr);
    idex_d.va  = rf_a;
    idex_d.vb  = rf_b;
    idex_d.off = sext_off(ifid_q.instr[OFF_W-1:0]);
    idex_d.pc1 = ifid_q.pc1;
  end

  // Interlock against producers in execute (index 0) and memory (index 1)
  logic [1:0]             prod_wr;
  logic [1:0][RSEL_W-1:0] prod_rd;
  assign prod_wr = {writes_reg(exmem_q.op), writes_reg(idex_q.op)};
  assign prod_rd = {exmem_q.rd, idex_q.rd};

  p5_hazard #(.NSTG(2), .SW(RSEL_W)) u_hz (
    .dec_active(d_op != OP_NOOP), .dec_ra(d_ra), .dec_rb(d_rb),
    .prod_wr(prod_wr), .prod_rd(prod_rd), .stall(hz_stall)
  );

  // Execute
  always_comb begin
    exmem_d.op     = idex_q.op;
    exmem_d.rd     = idex_q.rd;
    exmem_d.alu    = alu_calc(idex_q.op, idex_q.va, idex_q.vb, idex_q.off);
    exmem_d.vb     = idex_q.vb;
    exmem_d.target = branch_target(idex_q.pc1, idex_q.off);
    exmem_d.eq     = (idex_q.va == idex_q.vb);
  end

  // Memory
  logic              m_store;
  logic [WORD_W-1:0] m_rdata;
  assign m_store   = (exmem_q.op == OP_SW);
  assign br_take   = (exmem_q.op == OP_BEQ) && exmem_q.eq;
  assign br_target = exmem_q.target;

  p5_wordmem #(.DEPTH(DMEM_DEPTH), .W(WORD_W)) u_dmem (
    .clk(clk), .we(dmem_we || m_store),
    .waddr(dmem_we ? dmem_waddr : exmem_q.alu[DAW-1:0]),
    .wdata(dmem_we ? dmem_wdata : exmem_q.vb),
    .raddr0(exmem_q.alu[DAW-1:0]), .rdata0(m_rdata),
    .raddr1(mon_daddr), .rdata1(mon_ddata)
  );

  always_comb begin
    memwb_d.op    = exmem_q.op;
    memwb_d.rd    = exmem_q.rd;
    memwb_d.alu   = exmem_q.alu;
    memwb_d.mdata = m_rdata;
  end

  // Writeback
  assign wb_we   = writes_reg(memwb_q.op);
  assign wb_data = (memwb_q.op == OP_LW) ? memwb_q.mdata : memwb_q.alu;

  // Pipeline registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= '0;
      ifid_q  <= IFID_NOP;
      idex_q  <= IDEX_NOP;
      exmem_q <= EXMEM_NOP;
      memwb_q <= MEMWB_NOP;
    end else begin
      memwb_q <= memwb_d;
      if (br_take) begin
        pc_q    <= br_target;
        ifid_q  <= IFID_NOP;
        idex_q  <= IDEX_NOP;
        exmem_q <= EXMEM_NOP;
      end else if (hz_stall) begin
        idex_q  <= IDEX_NOP;
        exmem_q <= exmem_d;
      end else begin
        pc_q    <= ifid_d.pc1;
        ifid_q  <= ifid_d;
        idex_q  <= idex_d;
        exmem_q <= exmem_d;
      end
    end
  end

  assign ifid_nop  = (op_of(ifid_q.instr) == OP_NOOP);
  assign idex_nop  = (idex_q.op == OP_NOOP);
  assign exmem_nop = (exmem_q.op == OP_NOOP);
endmodule

// File: rtl/p5_core_chk.sv
`timescale 1ns/1ps
module p5_core_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         hz_stall,
  input logic         br_take,
  input logic [W-1:0] pc_q,
  input logic [W-1:0] br_target,
  input logic [W-1:0] ifid_word,
  input logic         ifid_nop,
  input logic         idex_nop,
  input logic         exmem_nop
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hz_stall && !br_take) |=> ($stable(pc_q) && $stable(ifid_word) && idex_nop));

  // R9
  squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_take |=> (ifid_nop && idex_nop && exmem_nop && (pc_q == $past(br_target))));

  // R8
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hz_stall && !br_take) |=> (pc_q == $past(pc_q) + 1'b1));

  // R5
  stall_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hz_stall && $past(hz_stall)) |=> !hz_stall);
endmodule

bind pipe5_core p5_core_chk #(.W(p5_pkg::WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hz_stall(hz_stall), .br_take(br_take),
  .pc_q(pc_q), .br_target(br_target), .ifid_word(ifid_q.instr),
  .ifid_nop(ifid_nop), .idex_nop(idex_nop), .exmem_nop(exmem_nop)
);

// File: tb/tb_pipe5_core.sv
`timescale 1ns/1ps
module tb_pipe5_core;
  localparam logic [2:0] K_ADD = 3'd0, K_NAND = 3'd1, K_LW = 3'd2,
                         K_SW = 3'd3, K_BEQ = 3'd4, K_NOP = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_we = 1'b0, dmem_we = 1'b0;
  logic [5:0]  imem_waddr = '0, dmem_waddr = '0, mon_iaddr = '0, mon_daddr = '0;
  logic [31:0] imem_wdata = '0, dmem_wdata = '0;
  logic [2:0]  mon_rsel = '0;
  logic [31:0] mon_idata, mon_ddata, mon_rdata;

  int checks = 0, fails = 0, ecnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pipe5_core dut (
    .clk(clk), .rst_n(rst_n),
    .imem_we(imem_we), .imem_waddr(imem_waddr), .imem_wdata(imem_wdata),
    .dmem_we(dmem_we), .dmem_waddr(dmem_waddr), .dmem_wdata(dmem_wdata),
    .mon_iaddr(mon_iaddr), .mon_idata(mon_idata),
    .mon_daddr(mon_daddr), .mon_ddata(mon_ddata),
    .mon_rsel(mon_rsel), .mon_rdata(mon_rdata)
  );

  // a, b, expected a+b, expected ~(a&b)
  localparam logic [31:0] TV [4][4] = '{
    '{32'h0000_0005, 32'h0000_0007, 32'h0000_000C, 32'hFFFF_FFFA},
    '{32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 32'hFFFF_FFFE},
    '{32'h0F0F_0F0F, 32'h00FF_00FF, 32'h100E_100E, 32'hFFF0_FFF0},
    '{32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 32'h7FFF_FFFF}
  };

  function automatic logic [31:0] enc(logic [2:0] op, logic [2:0] a, logic [2:0] b, logic [15:0] f);
    return {7'd0, op, a, b, f};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic iw(int a, logic [31:0] w);
    @(negedge clk); imem_we = 1'b1; imem_waddr = 6'(a); imem_wdata = w;
    @(posedge clk); #1 imem_we = 1'b0;
  endtask

  task automatic dw(int a, logic [31:0] w);
    @(negedge clk); dmem_we = 1'b1; dmem_waddr = 6'(a); dmem_wdata = w;
    @(posedge clk); #1 dmem_we = 1'b0;
  endtask

  task automatic prog_clear();
    rst_n = 1'b0;
    for (int a = 0; a < 64; a++) iw(a, enc(K_NOP, 3'd0, 3'd0, 16'd0));
  endtask

  task automatic go();
    @(negedge clk); rst_n = 1'b1; ecnt = 0;
  endtask

  task automatic step_to(int n);
    while (ecnt < n) begin @(posedge clk); ecnt++; end
    #1;
  endtask

  task automatic rreg(logic [2:0] r, output logic [31:0] v);
    mon_rsel = r; #0.1 v = mon_rdata;
  endtask

  task automatic rmem(int a, output logic [31:0] v);
    mon_daddr = 6'(a); #0.1 v = mon_ddata;
  endtask

  // Producer add R3 at address 5, consumer nand R6 <- ~(R3&R3) after gap noops
  task automatic dep_prog(int gap);
    prog_clear();
    dw(0, 32'd3); dw(1, 32'd4);
    iw(0, enc(K_LW, 3'd0, 3'd1, 16'd0));
    iw(1, enc(K_LW, 3'd0, 3'd2, 16'd1));
    iw(5, enc(K_ADD, 3'd1, 3'd2, 16'd3));
    iw(6 + gap, enc(K_NAND, 3'd3, 3'd3, 16'd6));
    go();
  endtask

  logic [31:0] v;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R11: load ports and monitor read-back
    prog_clear();
    iw(5, 32'h1234_5678); dw(9, 32'hCAFE_0001);
    mon_iaddr = 6'd5; rmem(9, v);
    chk("R11 dmem readback", v, 32'hCAFE_0001);
    chk("R11 imem readback", mon_idata, 32'h1234_5678);

    // R2 / R3: table of operand pairs through lw, add, nand, sw
    for (int i = 0; i < 4; i++) begin
      prog_clear();
      dw(0, TV[i][0]); dw(1, TV[i][1]); dw(10, 32'hDEAD_BEEF);
      iw(0, enc(K_LW, 3'd0, 3'd1, 16'd0));
      iw(1, enc(K_LW, 3'd0, 3'd2, 16'd1));
      iw(2, enc(K_ADD, 3'd1, 3'd2, 16'd3));
      iw(3, enc(K_NAND, 3'd1, 3'd2, 16'd4));
      iw(4, enc(K_SW, 3'd0, 3'd3, 16'd10));
      go(); step_to(30);
      rreg(3'd3, v); chk("R2 add result", v, TV[i][2]);
      rreg(3'd4, v); chk("R2 nand result", v, TV[i][3]);
      rmem(10, v);   chk("R3 sw stored", v, TV[i][2]);
    end

    // R2 timing and R5 back-to-back dependence (two stall cycles)
    dep_prog(0);
    step_to(4);  rreg(3'd1, v); chk("R2 before 5th edge", v, 32'd0);
    step_to(5);  rreg(3'd1, v); chk("R2 at 5th edge", v, 32'd3);
    step_to(9);  rreg(3'd3, v); chk("R5 producer early", v, 32'd0);
    step_to(10); rreg(3'd3, v); chk("R5 producer write", v, 32'd7);
    step_to(12); rreg(3'd6, v); chk("R5 consumer not early", v, 32'd0);
    step_to(13); rreg(3'd6, v); chk("R5 consumer after 2 stalls", v, 32'hFFFF_FFF8);

    // R6: one slot apart -> one stall; two apart -> none; both land at edge 13
    for (int g = 1; g <= 2; g++) begin
      dep_prog(g);
      step_to(12); rreg(3'd6, v); chk("R6 consumer not early", v, 32'd0);
      step_to(13); rreg(3'd6, v); chk("R6 consumer timing", v, 32'hFFFF_FFF8);
    end

    // R7 / R8: sw (bits2:0=3) and untaken beq (offset 3) ahead of a reader of R3
    prog_clear();
    dw(0, 32'd3); dw(1, 32'd4); dw(2, 32'd10); dw(3, 32'd0);
    iw(0, enc(K_LW, 3'd0, 3'd1, 16'd0));
    iw(1, enc(K_LW, 3'd0, 3'd2, 16'd1));
    iw(2, enc(K_LW, 3'd0, 3'd3, 16'd2));
    iw(5, enc(K_SW, 3'd0, 3'd1, 16'd3));
    iw(6, enc(K_BEQ, 3'd1, 3'd2, 16'd3));
    iw(7, enc(K_ADD, 3'd3, 3'd3, 16'd5));
    go();
    step_to(11); rreg(3'd5, v); chk("R7 no early write", v, 32'd0);
    step_to(12); rreg(3'd5, v); chk("R7 R8 no stall no branch penalty", v, 32'd20);
    step_to(20); rmem(3, v);    chk("R3 sw to regA+offset", v, 32'd3);

    // R9: taken beq at 5 -> target 9; adds at 6..8 discarded
    prog_clear();
    dw(0, 32'd3);
    iw(0, enc(K_LW, 3'd0, 3'd1, 16'd0));
    iw(1, enc(K_LW, 3'd0, 3'd2, 16'd0));
    iw(5, enc(K_BEQ, 3'd1, 3'd2, 16'd3));
    iw(6, enc(K_ADD, 3'd1, 3'd1, 16'd4));
    iw(7, enc(K_ADD, 3'd1, 3'd1, 16'd5));
    iw(8, enc(K_ADD, 3'd1, 3'd1, 16'd6));
    iw(9, enc(K_NAND, 3'd1, 3'd1, 16'd7));
    go();
    step_to(13); rreg(3'd7, v); chk("R9 target not early", v, 32'd0);
    step_to(14); rreg(3'd7, v); chk("R9 target result", v, 32'hFFFF_FFFC);
    step_to(25);
    rreg(3'd4, v); chk("R9 squashed slot 1", v, 32'd0);
    rreg(3'd5, v); chk("R9 squashed slot 2", v, 32'd0);
    rreg(3'd6, v); chk("R9 squashed slot 3", v, 32'd0);

    // R3 negative offset, R4 undefined opcodes, R5 stall on lw->lw
    prog_clear();
    dw(0, 32'd3); dw(2, 32'd10);
    iw(0, enc(K_LW, 3'd0, 3'd1, 16'd0));
    iw(1, enc(K_LW, 3'd1, 3'd2, 16'hFFFF));
    iw(2, enc(3'd6, 3'd2, 3'd2, 16'd7));
    iw(3, enc(K_ADD, 3'd1, 3'd1, 16'd3));
    iw(4, enc(3'd5, 3'd1, 3'd1, 16'd7));
    go();
    step_to(7);  rreg(3'd2, v); chk("R5 lw after lw stalls", v, 32'd0);
    step_to(8);  rreg(3'd2, v); chk("R3 negative offset load", v, 32'd10);
    step_to(9);  rreg(3'd3, v); chk("R4 no early write", v, 32'd0);
    step_to(10); rreg(3'd3, v); chk("R4 opcode 6 caused no stall", v, 32'd6);
    step_to(20); rreg(3'd7, v); chk("R4 opcode 5/6 wrote nothing", v, 32'd0);

    // R1: reset clears every register
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    for (int r = 0; r < 8; r++) begin
      rreg(3'(r), v); chk("R1 register cleared by reset", v, 32'd0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule